// File: doc/BRIEF.md
# System clock gear selector with low-power modes

This block turns one of three free-running source clocks, each modelled as a one-cycle enable pulse on the fabric clock, into the system clock enable. The three sources are a high-frequency oscillator, a ring oscillator and a 32 kHz oscillator. A four-bit control register picks the divide ratio, selects low-power operation and sets a switchback option. A ring-mode status input chooses between the high-frequency and ring sources when the slow source is not in use.

With low power off, the two ratio bits give divide-by-1, 2, 4 or 8 of the current fast source. With low power on, ratio codes 00, 01 and 10 give divide-by-256, and code 11 moves the system clock to the 32 kHz source. The ratio bits are frozen while low power is on, so they hold the ratio used after exit. The high-frequency oscillator enable drops only in the 32 kHz mode, and only when switchback is off. Ratio and source changes take effect at the divider's next terminal count, so the block never emits a shortened period. The one exception is leaving low power, which applies at once.

Register layout: bits [1:0] ratio select, bit 2 low-power enable, bit 3 switchback enable.

Top module: `sysclk_gear`

## Requirements
- R1: After reset the register reads 4'b0000, the system clock enable follows every high-frequency tick (divide-by-1), the oscillator enable is 1, switchback status is 0, and `sys_ce_o` is 0 when no tick is present.
- R2: With bit 2 = 0, ratio codes 00/01/10/11 make `sys_ce_o` pulse on every 1st/2nd/4th/8th tick of the current fast source. A tick pulses `sys_ce_o` only in the cycle in which that source's tick input is high.
- R3: With bit 2 = 1 and ratio code 00, 01 or 10, `sys_ce_o` pulses on every 256th tick of the current fast source.
- R4: With bit 2 = 1 and ratio code 11, `sys_ce_o` follows every 32 kHz tick whatever the ring-mode input, and ticks of the other sources produce no pulse.
- R5: Writes to bits [1:0] are ignored while bit 2 reads 1. Bits 2 and 3 are always writable, and all bits read back.
- R6: `hf_osc_en_o` is 0 only while the 32 kHz mode is both active and requested with bit 3 = 0. It is 1 in that mode with bit 3 = 1 and in every other mode.
- R7: With ring mode high and no 32 kHz mode, the ring source drives the divider and `hf_running_o` is 0. In the 32 kHz mode `hf_running_o` equals bit 3. Otherwise `hf_running_o` is 1.
- R8: `swb_active_o` is 1 exactly when bits 2 and 3 are both 1.
- R9: A new ratio written while low power is off takes effect only after the current period's terminal-count tick, so the old period completes in full.
- R10: Clearing bit 2 raises `hf_osc_en_o` in the first cycle the register shows 0. The held ratio applies from the next clock edge with the partial count discarded.
- R11: `src_ce_o` is one-hot or zero. Its set bit marks the source now driving the divider (bit 0 high-frequency, bit 1 ring, bit 2 32 kHz), and its OR equals `sys_ce_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 4 | Register write value |
| cfg_rd_data | output | 4 | Register read value |
| ring_mode_i | input | 1 | Ring oscillator selected as fast source |
| hf_tick_i | input | 1 | High-frequency source enable pulse |
| ring_tick_i | input | 1 | Ring source enable pulse |
| slow_tick_i | input | 1 | 32 kHz source enable pulse |
| sys_ce_o | output | 1 | System clock enable |
| src_ce_o | output | 3 | System clock enable split by driving source |
| hf_osc_en_o | output | 1 | High-frequency oscillator enable |
| hf_running_o | output | 1 | High-frequency oscillator reported running |
| swb_active_o | output | 1 | Switchback status |

## Verification
The checker checks on every cycle that the per-source enables are one-hot and agree with the system enable. It also checks that the oscillator turns off only under a 32 kHz, no-switchback setting, that the ratio bits never change while low power was set, that the oscillator is back on when low power clears, and that the switchback status follows its two register bits. Divide ratios, source choice, resistance to foreign ticks, the wait for terminal count and the discarded partial count on exit all depend on tick sequences, so only the bench's table walk and directed cases can show them.

// File: rtl/sck_pkg.sv
package sck_pkg;
  localparam int SEL_W   = 2;
  localparam int REG_W   = SEL_W + 2;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_HF   = 2'd0,
    SRC_RING = 2'd1,
    SRC_SLOW = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    DIV_1  = 3'd0,
    DIV_2  = 3'd1,
    DIV_4  = 3'd2,
    DIV_8  = 3'd3,
    DIV_LP = 3'd4
  } ratio_e;

  typedef struct packed {
    src_e   src;
    ratio_e ratio;
  } gear_t;
endpackage

// File: rtl/sck_ctrl_reg.sv
module sck_ctrl_reg
  import sck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel,
  output logic             lp_en,
  output logic             swb_en,
  output logic [REG_W-1:0] rd_data
);
  localparam int LP_BIT  = SEL_W;
  localparam int SWB_BIT = SEL_W + 1;

  logic [SEL_W-1:0] sel_q;
  logic             lp_q;
  logic             swb_q;

  // Ratio bits frozen while low power is set (lock judged on the current value)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      lp_q  <= 1'b0;
      swb_q <= 1'b0;
    end else if (wr_en) begin
      if (!lp_q) sel_q <= wr_data[SEL_W-1:0];
      lp_q  <= wr_data[LP_BIT];
      swb_q <= wr_data[SWB_BIT];
    end
  end

  assign sel     = sel_q;
  assign lp_en   = lp_q;
  assign swb_en  = swb_q;
  assign rd_data = {swb_q, lp_q, sel_q};
endmodule

// File: rtl/sck_mode_decode.sv
module sck_mode_decode
  import sck_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             lp_en,
  input  logic             ring_mode,
  output gear_t            req_gear
);
  always_comb begin
    req_gear.src   = ring_mode ? SRC_RING : SRC_HF;
    req_gear.ratio = DIV_1;
    if (lp_en) begin
      if (sel == 2'b11) begin
        req_gear.src   = SRC_SLOW;
        req_gear.ratio = DIV_1;
      end else begin
        req_gear.ratio = DIV_LP;
      end
    end else begin
      unique case (sel)
        2'b00:   req_gear.ratio = DIV_1;
        2'b01:   req_gear.ratio = DIV_2;
        2'b10:   req_gear.ratio = DIV_4;
        default: req_gear.ratio = DIV_8;
      endcase
    end
  end
endmodule

// File: rtl/sck_divider.sv
module sck_divider
  import sck_pkg::*;
#(
  parameter  int LP_DIV = 256,
  localparam int CNT_W  = $clog2(LP_DIV)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  gear_t              req_gear,
  input  logic               lp_en,
  input  logic [NUM_SRC-1:0] src_tick,
  output src_e               act_src,
  output logic               sys_ce,
  output logic [NUM_SRC-1:0] src_ce
);
  gear_t            act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel_tick;
  logic             term;
  logic             act_lp;
  logic             exit_lp;

  function automatic logic [CNT_W-1:0] last_count(ratio_e r);
    case (r)
      DIV_2:   return CNT_W'(1);
      DIV_4:   return CNT_W'(3);
      DIV_8:   return CNT_W'(7);
      DIV_LP:  return CNT_W'(LP_DIV - 1);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    case (act_q.src)
      SRC_RING: sel_tick = src_tick[SRC_RING];
      SRC_SLOW: sel_tick = src_tick[SRC_SLOW];
      default:  sel_tick = src_tick[SRC_HF];
    endcase
  end

  assign term    = (cnt_q == last_count(act_q.ratio));
  assign act_lp  = (act_q.ratio == DIV_LP) || (act_q.src == SRC_SLOW);
  assign exit_lp = act_lp && !lp_en;
  assign sys_ce  = sel_tick && term && !exit_lp;

  // New gear is adopted at terminal count, or at once when leaving low power
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '{src: SRC_HF, ratio: DIV_1};
      cnt_q <= '0;
    end else if (exit_lp) begin
      act_q <= req_gear;
      cnt_q <= '0;
    end else if (sel_tick) begin
      if (term) begin
        act_q <= req_gear;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_ce
    assign src_ce[s] = sys_ce && (act_q.src == src_e'(s));
  end

  assign act_src = act_q.src;
endmodule

// File: rtl/sysclk_gear.sv
module sysclk_gear
  import sck_pkg::*;
#(
  parameter int LP_DIV = 256
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             ring_mode_i,
  input  logic             hf_tick_i,
  input  logic             ring_tick_i,
  input  logic             slow_tick_i,
  output logic             sys_ce_o,
  output logic [NUM_SRC-1:0] src_ce_o,
  output logic             hf_osc_en_o,
  output logic             hf_running_o,
  output logic             swb_active_o
);
  logic [SEL_W-1:0]   sel;
  logic               lp_en;
  logic               swb_en;
  gear_t              req_gear;
  src_e               act_src;
  logic [NUM_SRC-1:0] ticks;
  logic               slow_now;

  sck_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .sel     (sel),
    .lp_en   (lp_en),
    .swb_en  (swb_en),
    .rd_data (cfg_rd_data)
  );

  sck_mode_decode u_dec (
    .sel       (sel),
    .lp_en     (lp_en),
    .ring_mode (ring_mode_i),
    .req_gear  (req_gear)
  );

  assign ticks = {slow_tick_i, ring_tick_i, hf_tick_i};

  sck_divider #(.LP_DIV(LP_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_gear (req_gear),
    .lp_en    (lp_en),
    .src_tick (ticks),
    .act_src  (act_src),
    .sys_ce   (sys_ce_o),
    .src_ce   (src_ce_o)
  );

  // Slow mode counts only while both adopted and still requested
  assign slow_now     = (act_src == SRC_SLOW) && (req_gear.src == SRC_SLOW);
  assign hf_osc_en_o  = !(slow_now && !swb_en);
  assign hf_running_o = slow_now ? swb_en : !ring_mode_i;
  assign swb_active_o = lp_en && swb_en;
endmodule

// File: rtl/sysclk_gear_chk.sv
module sysclk_gear_chk
  import sck_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [REG_W-1:0]   cfg_rd_data,
  input logic               sys_ce_o,
  input logic [NUM_SRC-1:0] src_ce_o,
  input logic               hf_osc_en_o,
  input logic               swb_active_o
);
  // R11
  a_r11_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ce_o) && ((|src_ce_o) == sys_ce_o));

  // R6
  a_r6_osc_off_only_slow: assert property (@(posedge clk) disable iff (!rst_n)
    !hf_osc_en_o |-> (cfg_rd_data[2] && cfg_rd_data[1:0] == 2'b11 && !cfg_rd_data[3]));

  // R5
  a_r5_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[2] |=> (cfg_rd_data[1:0] == $past(cfg_rd_data[1:0])));

  // R10
  a_r10_osc_back: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rd_data[2]) |-> hf_osc_en_o);

  // R8
  a_r8_swb_status: assert property (@(posedge clk) disable iff (!rst_n)
    swb_active_o |-> (cfg_rd_data[3] && cfg_rd_data[2]));
endmodule

bind sysclk_gear sysclk_gear_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rd_data  (cfg_rd_data),
  .sys_ce_o     (sys_ce_o),
  .src_ce_o     (src_ce_o),
  .hf_osc_en_o  (hf_osc_en_o),
  .swb_active_o (swb_active_o)
);

// File: tb/test_sysclk_gear.sv
module test_sysclk_gear;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [3:0] cfg_wr_data = 4'h0;
  logic [3:0] cfg_rd_data;
  logic       ring_mode_i = 1'b0;
  logic       hf_tick_i = 1'b0;
  logic       ring_tick_i = 1'b0;
  logic       slow_tick_i = 1'b0;
  logic       sys_ce_o;
  logic [2:0] src_ce_o;
  logic       hf_osc_en_o;
  logic       hf_running_o;
  logic       swb_active_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sysclk_gear i_sysclk_gear (.*);

  typedef struct packed {
    logic       ring;
    logic [3:0] regv;   // {switchback, low power, ratio[1:0]}
    logic [1:0] src;    // 0 hf, 1 ring, 2 slow
    logic [8:0] n;
    logic       osc;
    logic       swba;
    logic       hfr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'b0000, 2'd0, 9'd1,   1'b1, 1'b0, 1'b1},
    '{1'b0, 4'b0001, 2'd0, 9'd2,   1'b1, 1'b0, 1'b1},
    '{1'b0, 4'b0010, 2'd0, 9'd4,   1'b1, 1'b0, 1'b1},
    '{1'b0, 4'b0011, 2'd0, 9'd8,   1'b1, 1'b0, 1'b1},
    '{1'b0, 4'b0100, 2'd0, 9'd256, 1'b1, 1'b0, 1'b1},
    '{1'b0, 4'b1100, 2'd0, 9'd256, 1'b1, 1'b1, 1'b1},
    '{1'b0, 4'b0101, 2'd0, 9'd256, 1'b1, 1'b0, 1'b1},
    '{1'b1, 4'b0000, 2'd1, 9'd1,   1'b1, 1'b0, 1'b0},
    '{1'b1, 4'b0011, 2'd1, 9'd8,   1'b1, 1'b0, 1'b0},
    '{1'b1, 4'b0110, 2'd1, 9'd256, 1'b1, 1'b0, 1'b0},
    '{1'b0, 4'b0111, 2'd2, 9'd1,   1'b0, 1'b0, 1'b0},
    '{1'b1, 4'b0111, 2'd2, 9'd1,   1'b0, 1'b0, 1'b0},
    '{1'b0, 4'b1111, 2'd2, 9'd1,   1'b1, 1'b1, 1'b1},
    '{1'b1, 4'b1111, 2'd2, 9'd1,   1'b1, 1'b1, 1'b1}
  };

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] t);
    @(negedge clk);
    {slow_tick_i, ring_tick_i, hf_tick_i} = t;
    #1;
  endtask

  task automatic wr(logic [3:0] v);
    @(negedge clk);
    {slow_tick_i, ring_tick_i, hf_tick_i} = 3'b000;
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(posedge clk);
    #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {slow_tick_i, ring_tick_i, hf_tick_i} = 3'b000;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  function automatic string tag_of(vec_t v);
    if (v.src == 2'd2) return "R4";
    if (v.ring)        return "R7";
    if (v.n == 9'd256) return "R3";
    return "R2";
  endfunction

  initial begin
    do_reset();
    // R1 reset state
    drive(3'b000);
    check("R1", "rd_data", cfg_rd_data, 0);
    check("R1", "osc_en", hf_osc_en_o, 1);
    check("R1", "swb_active", swb_active_o, 0);
    check("R1", "hf_running", hf_running_o, 1);
    check("R1", "idle ce", sys_ce_o, 0);
    drive(3'b001);
    check("R1", "div1 ce", sys_ce_o, 1);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      int bad = 0;
      logic [2:0] own = 3'b001 << v.src;
      do_reset();
      ring_mode_i = v.ring;
      wr(v.regv);
      drive(3'b001);          // terminal tick of reset gear adopts new gear
      drive(3'b000);
      check("R6", "osc_en", hf_osc_en_o, v.osc);
      check("R8", "swb_active", swb_active_o, v.swba);
      check("R7", "hf_running", hf_running_o, v.hfr);
      for (int t = 0; t < 2 * v.n; t++) begin
        drive(~own);
        if (sys_ce_o !== 1'b0) bad++;
        drive(own);
        if (sys_ce_o !== ((t % v.n) == v.n - 1)) bad++;
        if (src_ce_o !== (sys_ce_o ? own : 3'b000)) bad++;  // R11
      end
      check(tag_of(v), $sformatf("vector %0d period errors", k), bad, 0);
    end
    ring_mode_i = 1'b0;

    // R5 ratio lock
    do_reset();
    wr(4'b0100);
    wr(4'b0111);
    check("R5", "locked write", cfg_rd_data, 4'b0100);
    wr(4'b0011);
    check("R5", "unlock write", cfg_rd_data, 4'b0000);
    wr(4'b0010);
    check("R5", "free write", cfg_rd_data, 4'b0010);

    // R9 ratio change waits for terminal count
    begin
      int bad = 0;
      do_reset();
      wr(4'b0011);
      drive(3'b001);
      for (int t = 0; t < 3; t++) drive(3'b001);
      wr(4'b0000);
      for (int t = 0; t < 5; t++) begin
        drive(3'b001);
        if (sys_ce_o !== (t == 4)) bad++;
      end
      drive(3'b001);
      if (sys_ce_o !== 1'b1) bad++;
      check("R9", "ce pattern errors", bad, 0);
    end

    // R10 exit from 32 kHz mode
    begin
      int bad = 0;
      do_reset();
      wr(4'b0111);
      drive(3'b001);
      drive(3'b000);
      check("R6", "osc off in slow", hf_osc_en_o, 0);
      wr(4'b0011);
      check("R10", "osc_en on exit", hf_osc_en_o, 1);
      check("R10", "rd on exit", cfg_rd_data, 4'b0011);
      drive(3'b000);
      for (int t = 0; t < 8; t++) begin
        drive(3'b001);
        if (sys_ce_o !== (t == 7)) bad++;
      end
      check("R10", "held div8 after exit", bad, 0);
    end

    // R10 partial divide-by-256 count discarded
    do_reset();
    wr(4'b0100);
    drive(3'b001);
    for (int t = 0; t < 100; t++) drive(3'b001);
    wr(4'b0000);
    drive(3'b000);
    drive(3'b001);
    check("R10", "div1 right after exit", sys_ce_o, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule